// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block accepts a configuration bitstream one bit per configuration clock and decides, bit by bit, what the next device in a daisy chain gets to see. It waits through a run of idle ones and hunts for the four-bit start code `0010`. It then takes a 24-bit count of configuration clocks and slices the rest of the stream into frames. Each frame opens with a start bit, carries a fixed number of payload bits and closes with a four-bit check pattern. A good frame is handed to configuration memory through a one-cycle write strobe. A bad check pattern stops loading and raises an active-low error flag.

The downstream output carries the start code and the count, so chained devices can see them. It is forced high while frames load, so a chained device never mistakes a frame start bit for its own data. Once the last frame is in, the output follows the input again. In express mode the count is captured but has no effect. The downstream output then works as an enable: it stays low until this device is fully loaded, then goes high. A designated payload bit of the first frame asks for an eight-times faster configuration clock. A start-up request tells the start-up logic when the stream is complete. The clock count that the host supplies includes the four trailing clocks needed after the last frame.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `err_n` is 1 and `frame_we`, `fast_clk_sel` and `startup_req` are 0. In serial mode `dout` equals `din` in the same cycle.
- R2: Leading ones are ignored. The code `0010` (first bit received first) is found on any four consecutive bits, including after extra zeros.
- R3: In serial mode, `dout` equals `din` during the idle bits, the start code and the 24 count bits. The count is taken most significant bit first.
- R4: In serial mode, once the 24th count bit has been taken, `dout` is 1 for every bit of every frame, whatever `din` is.
- R5: A frame is made of a start bit of 0, then FRAME_BITS payload bits, then four check bits that must equal 0110 (first received bit is bit 3). Ones in place of the start bit are skipped. A matching frame gives a `frame_we` pulse lasting exactly one cycle, in the cycle after the last check bit. `frame_data` then holds the payload with the first received bit as its MSB.
- R6: A check field other than 0110 drives `err_n` to 0 in the cycle after its last bit, and no `frame_we` is given for that frame. After that, `err_n` stays 0 and `frame_we` stays 0 until reset, whatever frames follow. In serial mode `dout` stays 1 while halted.
- R7: In serial mode, after NUM_FRAMES good frames, `dout` equals `din` again.
- R8: In serial mode, clocks are counted from the first bit of the start code. `startup_req` rises in the cycle after the clock whose count equals the captured length, and stays 1. It is not set earlier.
- R9: `fast_clk_sel` is set and stays 1 once payload bit index FAST_BIT_IDX (index 0 is the first received) of the first frame arrives as 1. The same position in later frames has no effect.
- R10: In express mode, `dout` is 0 from reset until the last frame completes and 1 after it. The captured count has no effect, and `startup_req` rises together with the last frame's write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial configuration data |
| express_mode | input | 1 | 1 selects express (enable-chain) mode; held stable outside reset |
| dout | output | 1 | Downstream data or enable line |
| err_n | output | 1 | Active-low frame error flag, open-drain style |
| frame_we | output | 1 | One-cycle write strobe for a verified frame |
| frame_data | output | FRAME_BITS | Payload of the last verified frame |
| fast_clk_sel | output | 1 | Request for the eight-times faster configuration clock |
| startup_req | output | 1 | Request to begin the start-up sequence |

## Verification
The bench builds the loader with eight-bit frames, two frames per stream and the fast-clock bit at payload index 1. A full stream then fits in under sixty clocks. The start-up threshold can be put four clocks past the last frame and checked one clock before and at the exact count. With these values, the express-mode run can place the ignored length inside the first frame, which checks that the count comparison is really switched off. The short streams also make room for a full frame sent after a halt.

// File: rtl/sload_pkg.sv
package sload_pkg;
  localparam int LEN_W = 24;
  localparam int PRE_W = 4;
  localparam int CHK_W = 4;
  localparam logic [PRE_W-1:0] PRE_CODE = 4'b0010;

  typedef enum logic [2:0] {LD_HUNT, LD_LEN, LD_FRAME, LD_DONE, LD_HALT} ld_state_t;
  typedef enum logic [1:0] {FP_START, FP_DATA, FP_CHECK} fr_phase_t;

  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
    return (&v) ? v : v + LEN_W'(1);
  endfunction

  function automatic logic pre_match(input logic [PRE_W-2:0] hist, input logic b);
    return {hist, b} == PRE_CODE;
  endfunction

  function automatic logic chk_match(input logic [CHK_W-2:0] hist, input logic b,
                                     input logic [CHK_W-1:0] code);
    return {hist, b} == code;
  endfunction
endpackage

// File: rtl/sload_hunt.sv
module sload_hunt
  import sload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic hit
);
  logic [PRE_W-2:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hist_q <= '1;
    else if (en) hist_q <= {hist_q[PRE_W-3:0], din};
  end

  assign hit = en && pre_match(hist_q, din);
endmodule

// File: rtl/sload_len_ctr.sv
module sload_len_ctr
  import sload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_start,
  input  logic cap_en,
  input  logic run_en,
  input  logic cmp_en,
  input  logic din,
  output logic len_last,
  output logic reach
);
  localparam int IDX_W = $clog2(LEN_W);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [IDX_W-1:0] idx_q;

  assign cnt_nxt  = sat_inc(cnt_q);
  assign len_last = cap_en && (idx_q == IDX_W'(LEN_W-1));
  assign reach    = cmp_en && run_en && (cnt_nxt == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      if (cap_en) begin
        len_q <= {len_q[LEN_W-2:0], din};
        idx_q <= idx_q + IDX_W'(1);
      end
      if (load_start)  cnt_q <= LEN_W'(PRE_W);
      else if (run_en) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sload_frame.sv
module sload_frame
  import sload_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int NUM_FRAMES = 3,
  parameter int FAST_BIT_IDX = 1,
  parameter logic [3:0] ERR_CODE = 4'b0110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  din,
  output logic                  ok_evt,
  output logic                  bad_evt,
  output logic                  at_last,
  output logic                  fast_evt,
  output logic                  we,
  output logic [FRAME_BITS-1:0] data
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int FR_W  = $clog2(NUM_FRAMES + 1);
  localparam int CK_W  = $clog2(CHK_W);

  fr_phase_t             ph_q;
  logic [BIT_W-1:0]      bit_q;
  logic [CK_W-1:0]       ck_idx_q;
  logic [CHK_W-2:0]      ck_sh_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] data_q;
  logic [FR_W-1:0]       idx_q;
  logic                  we_q;
  logic                  data_last;
  logic                  ck_last;
  logic                  ck_good;

  assign data_last = (ph_q == FP_DATA) && (bit_q == BIT_W'(FRAME_BITS-1));
  assign ck_last   = (ph_q == FP_CHECK) && (ck_idx_q == CK_W'(CHK_W-1));
  assign ck_good   = chk_match(ck_sh_q, din, ERR_CODE);
  assign ok_evt    = en && ck_last && ck_good;
  assign bad_evt   = en && ck_last && !ck_good;
  assign at_last   = (idx_q == FR_W'(NUM_FRAMES-1));
  assign fast_evt  = en && (ph_q == FP_DATA) && (idx_q == '0)
                     && (bit_q == BIT_W'(FAST_BIT_IDX)) && din;
  assign we        = we_q;
  assign data      = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= FP_START;
      bit_q    <= '0;
      ck_idx_q <= '0;
      ck_sh_q  <= '0;
      sh_q     <= '0;
      data_q   <= '0;
      idx_q    <= '0;
      we_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (en) begin
        unique case (ph_q)
          FP_START: begin
            if (!din) begin
              ph_q  <= FP_DATA;
              bit_q <= '0;
            end
          end
          FP_DATA: begin
            sh_q  <= {sh_q[FRAME_BITS-2:0], din};
            bit_q <= bit_q + BIT_W'(1);
            if (data_last) begin
              ph_q     <= FP_CHECK;
              ck_idx_q <= '0;
            end
          end
          FP_CHECK: begin
            ck_sh_q  <= {ck_sh_q[CHK_W-3:0], din};
            ck_idx_q <= ck_idx_q + CK_W'(1);
            if (ck_last) begin
              ph_q <= FP_START;
              if (ck_good) begin
                we_q   <= 1'b1;
                data_q <= sh_q;
                idx_q  <= idx_q + FR_W'(1);
              end
            end
          end
          default: ph_q <= FP_START;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import sload_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int NUM_FRAMES = 3,
  parameter int FAST_BIT_IDX = 1,
  parameter logic [3:0] ERR_CODE = 4'b0110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic                  express_mode,
  output logic                  dout,
  output logic                  err_n,
  output logic                  frame_we,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  fast_clk_sel,
  output logic                  startup_req
);
  ld_state_t st_q;
  logic in_hunt, in_len, in_frame, in_done;
  logic pre_hit, len_last, reach;
  logic ok_evt, bad_evt, at_last, fast_evt, last_evt;
  logic err_n_q, startup_q, fast_q;

  assign in_hunt  = (st_q == LD_HUNT);
  assign in_len   = (st_q == LD_LEN);
  assign in_frame = (st_q == LD_FRAME);
  assign in_done  = (st_q == LD_DONE);
  assign last_evt = ok_evt && at_last;

  sload_hunt u_hunt (
    .clk(clk), .rst_n(rst_n), .en(in_hunt), .din(din), .hit(pre_hit)
  );

  sload_len_ctr u_len (
    .clk(clk), .rst_n(rst_n), .load_start(pre_hit), .cap_en(in_len),
    .run_en(in_len || in_frame || in_done),
    .cmp_en((in_frame || in_done) && !express_mode),
    .din(din), .len_last(len_last), .reach(reach)
  );

  sload_frame #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES),
    .FAST_BIT_IDX(FAST_BIT_IDX), .ERR_CODE(ERR_CODE)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .en(in_frame), .din(din),
    .ok_evt(ok_evt), .bad_evt(bad_evt), .at_last(at_last), .fast_evt(fast_evt),
    .we(frame_we), .data(frame_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LD_HUNT;
      err_n_q   <= 1'b1;
      startup_q <= 1'b0;
      fast_q    <= 1'b0;
    end else begin
      unique case (st_q)
        LD_HUNT:  if (pre_hit) st_q <= LD_LEN;
        LD_LEN:   if (len_last) st_q <= LD_FRAME;
        LD_FRAME: begin
          if (bad_evt)       st_q <= LD_HALT;
          else if (last_evt) st_q <= LD_DONE;
        end
        default: st_q <= st_q;
      endcase
      if (bad_evt) err_n_q <= 1'b0;
      if (reach || (express_mode && last_evt)) startup_q <= 1'b1;
      if (fast_evt) fast_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      LD_HUNT, LD_LEN:   dout = express_mode ? 1'b0 : din;
      LD_FRAME, LD_HALT: dout = !express_mode;
      LD_DONE:           dout = express_mode ? 1'b1 : din;
      default:           dout = 1'b1;
    endcase
  end

  assign err_n        = err_n_q;
  assign startup_req  = startup_q;
  assign fast_clk_sel = fast_q;
endmodule

// File: rtl/sload_checker.sv
module sload_checker (
  input logic clk,
  input logic rst_n,
  input logic express_mode,
  input logic dout,
  input logic err_n,
  input logic frame_we,
  input logic fast_clk_sel,
  input logic startup_req,
  input logic ok_evt
);
  // R5: strobe lasts exactly one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |=> !frame_we);

  // R5: strobe only follows a matching check field
  p_we_after_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |-> $past(ok_evt));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |=> !err_n);

  // R6: no frame accepted once halted
  p_quiet_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (!frame_we && !ok_evt));

  // R8: start-up request is sticky
  p_startup_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    startup_req |=> startup_req);

  // R9: fast clock selection is sticky
  p_fast_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_sel |=> fast_clk_sel);

  // R10: downstream enable low until this device has finished
  p_express_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (express_mode && !startup_req) |-> !dout);
endmodule

bind serial_cfg_loader sload_checker u_chk (
  .clk(clk), .rst_n(rst_n), .express_mode(express_mode), .dout(dout),
  .err_n(err_n), .frame_we(frame_we), .fast_clk_sel(fast_clk_sel),
  .startup_req(startup_req), .ok_evt(ok_evt)
);

// File: tb/serial_cfg_loader_bench.sv
module serial_cfg_loader_bench;
  localparam int FB = 8;
  localparam int NF = 2;
  localparam int FAST = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic express_mode = 1'b0;
  logic dout, err_n, frame_we, fast_clk_sel, startup_req;
  logic [FB-1:0] frame_data;
  logic dout_seen;
  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  serial_cfg_loader #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .FAST_BIT_IDX(FAST)) u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .din(din), .express_mode(express_mode),
    .dout(dout), .err_n(err_n), .frame_we(frame_we), .frame_data(frame_data),
    .fast_clk_sel(fast_clk_sel), .startup_req(startup_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic do_reset(input logic xm);
    rst_n = 1'b0;
    din = 1'b1;
    @(posedge clk); #5;
    express_mode = xm;
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
  endtask

  // present one bit, record dout before the edge, return 5 ns after the edge
  task automatic shift(input logic b);
    din = b;
    #2 dout_seen = dout;
    @(posedge clk); #5;
  endtask

  task automatic send_head(input logic [23:0] len, input logic exp_follow, input string req);
    int mism = 0;
    logic [3:0] pre = 4'b0010;
    for (int i = 3; i >= 0; i--) begin
      shift(pre[i]);
      if (dout_seen !== (exp_follow ? pre[i] : 1'b0)) mism++;
    end
    for (int i = 23; i >= 0; i--) begin
      shift(len[i]);
      if (dout_seen !== (exp_follow ? len[i] : 1'b0)) mism++;
    end
    chk(req, "dout over start code and count", mism, 0);
  endtask

  task automatic send_frame(input logic [FB-1:0] d, input logic [3:0] ck, input bit filler,
                            input logic exp_dout, input logic exp_we, input string req);
    int mism = 0;
    if (filler) begin
      shift(1'b1);
      if (dout_seen !== exp_dout) mism++;
    end
    shift(1'b0);
    if (dout_seen !== exp_dout) mism++;
    chk("R5", "frame_we low at frame start", frame_we, 0);
    for (int i = FB-1; i >= 0; i--) begin
      shift(d[i]);
      if (dout_seen !== exp_dout) mism++;
    end
    for (int i = 3; i >= 0; i--) begin
      shift(ck[i]);
      if (dout_seen !== exp_dout) mism++;
    end
    chk(req, "dout hold during frame", mism, 0);
    chk(req, "frame_we after check field", frame_we, exp_we);
    if (exp_we) chk(req, "frame_data", 32'(frame_data), 32'(d));
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1", "err_n", err_n, 1);
    chk("R1", "frame_we", frame_we, 0);
    chk("R1", "fast_clk_sel", fast_clk_sel, 0);
    chk("R1", "startup_req", startup_req, 0);
    din = 1'b0; #2 chk("R1", "dout follows din 0", dout, 0);
    din = 1'b1; #2 chk("R1", "dout follows din 1", dout, 1);
  endtask

  // clocks: 4 code + 24 count + 13 frame0 + 1 filler + 13 frame1 = 55; +4 = 59
  task automatic t_serial();
    int mism = 0;
    do_reset(1'b0);
    shift(1'b1); if (dout_seen !== 1'b1) mism++;
    shift(1'b1); if (dout_seen !== 1'b1) mism++;
    shift(1'b0); if (dout_seen !== 1'b0) mism++;
    chk("R3", "dout over idle bits", mism, 0);
    send_head(24'd59, 1'b1, "R3");
    chk("R9", "fast_clk_sel before first frame", fast_clk_sel, 0);
    send_frame(8'hC5, 4'b0110, 0, 1'b1, 1'b1, "R4");
    chk("R9", "fast_clk_sel after index bit set", fast_clk_sel, 1);
    chk("R2", "code found after extra zero", err_n, 1);
    send_frame(8'h3A, 4'b0110, 1, 1'b1, 1'b1, "R5");
    chk("R8", "startup_req before count reached", startup_req, 0);
    mism = 0;
    shift(1'b0); if (dout_seen !== 1'b0) mism++;
    shift(1'b1); if (dout_seen !== 1'b1) mism++;
    shift(1'b0); if (dout_seen !== 1'b0) mism++;
    chk("R7", "dout follows din after last frame", mism, 0);
    chk("R8", "startup_req one clock early", startup_req, 0);
    shift(1'b1);
    chk("R8", "startup_req at count", startup_req, 1);
    shift(1'b0);
    chk("R8", "startup_req stays", startup_req, 1);
  endtask

  task automatic t_fast_off();
    do_reset(1'b0);
    send_head(24'd1000, 1'b1, "R3");
    send_frame(8'h80, 4'b0110, 0, 1'b1, 1'b1, "R4");
    send_frame(8'h40, 4'b0110, 0, 1'b1, 1'b1, "R5");
    chk("R9", "later frame index bit ignored", fast_clk_sel, 0);
    chk("R8", "no startup below count", startup_req, 0);
    din = 1'b0; #2 chk("R7", "dout follows 0", dout, 0);
    din = 1'b1; #2 chk("R7", "dout follows 1", dout, 1);
  endtask

  task automatic t_error();
    do_reset(1'b0);
    send_head(24'd58, 1'b1, "R3");
    send_frame(8'h11, 4'b0110, 0, 1'b1, 1'b1, "R5");
    send_frame(8'h22, 4'b0111, 0, 1'b1, 1'b0, "R6");
    chk("R6", "err_n after bad check field", err_n, 0);
    send_frame(8'h33, 4'b0110, 0, 1'b1, 1'b0, "R6");
    chk("R6", "err_n stays low", err_n, 0);
    chk("R6", "no startup while halted", startup_req, 0);
    din = 1'b0; #2 chk("R6", "dout held high when halted", dout, 1);
    do_reset(1'b0);
    chk("R6", "err_n released by reset", err_n, 1);
  endtask

  // count of 40 falls inside frame 0 and must have no effect
  task automatic t_express();
    do_reset(1'b1);
    shift(1'b1);
    chk("R10", "dout low while idle", dout_seen, 0);
    send_head(24'd40, 1'b0, "R10");
    send_frame(8'h7E, 4'b0110, 0, 1'b0, 1'b1, "R10");
    chk("R10", "count ignored", startup_req, 0);
    chk("R9", "fast_clk_sel in express", fast_clk_sel, 1);
    send_frame(8'h01, 4'b0110, 0, 1'b0, 1'b1, "R10");
    chk("R10", "startup_req with last frame", startup_req, 1);
    din = 1'b0; #2 chk("R10", "dout high when loaded", dout, 1);
    do_reset(1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_serial();
    t_fast_off();
    t_error();
    t_express();
    report();
    $finish;
  end
endmodule